// File: doc/BRIEF.md
# Machine State Register Update Unit

This block keeps a 64-bit machine state register and applies the masked update rules of two register-write operations. One is a narrow write that touches only the low word's fields. The other is a full doubleword write. Each operation carries a one-bit partial flag. When the flag is set, the write is restricted to two control bits. When the flag is clear, the write covers a set of fixed bit ranges. A few bits are then set to the OR of their own source bit and a shared source bit. A three-bit transaction-state field is written only when a guard allows it. Every bit that no rule names keeps its value.

Bit positions use big-endian numbering: bit 0 is the most significant bit of the register, which is vector index 63. The update takes effect on the rising clock edge while the write strobe is high. The register value is always shown unchanged on the read port, which serves the read instruction. A synchronous reset loads a constant set by a parameter. Privilege checks, synchronisation side effects and interrupt delivery belong to the surrounding core.

Top module: `msr_write_unit`

## Requirements
- R1: A synchronous reset loads the parameter RST_VAL, and `msr_q` shows that value on the cycle after the reset edge.
- R2: While `wr_en` is low, the register holds its value, whatever the other inputs are.
- R3: With `part_l` = 1, either variant copies source bits 48 and 62 (big-endian) into the register and leaves all other bits unchanged.
- R4: With `part_l` = 0, either variant sets bits 48, 58 and 59 to the OR of the matching source bit and source bit 49.
- R5: With `part_l` = 0, either variant copies source bits 32–40, 42–47, 49–50, 52–57 and 60–62. Bits 41, 51 and 63 are never changed.
- R6: With `part_l` = 0 and `dword` = 1, source bits 0–2 and 4–28 are also copied. Bit 3 is never changed.
- R7: With `part_l` = 0 and `dword` = 1, field 29–31 takes the source value. The exception is when the current field is 3'b010 (bit 29 first) and the source field is 3'b000; then the field keeps its value.
- R8: With `dword` = 0, bits 0–31 are never changed.
- R9: `msr_q` shows the full register with no transformation, and it changes on the rising edge where `wr_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| dword | input | 1 | 1 = doubleword variant, 0 = narrow variant |
| part_l | input | 1 | Partial flag: 1 restricts the write to bits 48 and 62 |
| src | input | 64 | Source operand, bit 0 = index 63 |
| msr_q | output | 64 | Current register value |

## Verification
Every write is due on `msr_q` exactly one clock after the falling edge where the bench drives it: the single register stage updates on the rising edge between. The driver tags each expected value with the cycle number that follows that edge. The monitor compares on falling edges only once the cycle counter has reached the tag, so no value is read before or after its cycle. Idle cycles with the strobe low also push an expected value, which must equal the value already held. The reset value is sampled on the falling edge after the reset edge.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int XLEN = 64;
  typedef logic [XLEN-1:0] word_t;

  // Mask with big-endian bits lo..hi set.
  function automatic word_t be_span(int lo, int hi);
    word_t m;
    m = '0;
    for (int i = lo; i <= hi; i++) m[XLEN-1-i] = 1'b1;
    return m;
  endfunction

  // Shared source bit that forces selected bits on.
  localparam int    OR_SRC_BIT = 49;
  localparam int    NFORCE     = 3;
  localparam logic [NFORCE*8-1:0] FORCE_LIST = {8'd59, 8'd58, 8'd48};

  localparam word_t M_COMMON = be_span(32, 40) | be_span(42, 47) | be_span(49, 50)
                             | be_span(52, 57) | be_span(60, 62);
  localparam word_t M_WIDE   = be_span(0, 2) | be_span(4, 28);
  localparam word_t M_FORCE  = be_span(48, 48) | be_span(58, 58) | be_span(59, 59);
  localparam word_t M_PART   = be_span(48, 48) | be_span(62, 62);

  // Transaction-state field, big-endian bits 29..31 (29 is the field MSB).
  localparam int    TS_W       = 3;
  localparam int    TS_MSB     = XLEN - 1 - 29;
  localparam int    TS_LSB     = XLEN - 1 - 31;
  localparam word_t M_TS       = be_span(29, 31);
  localparam logic [TS_W-1:0] TS_HELD_CUR = 3'b010;
  localparam logic [TS_W-1:0] TS_HELD_SRC = 3'b000;
endpackage

// File: rtl/msr_force_or.sv
module msr_force_or
  import msr_pkg::*;
(
  input  word_t src,
  output word_t forced
);
  always_comb begin
    forced = '0;
    for (int i = 0; i < NFORCE; i++) begin
      forced[XLEN-1-int'(FORCE_LIST[8*i +: 8])] =
        src[XLEN-1-int'(FORCE_LIST[8*i +: 8])] | src[XLEN-1-OR_SRC_BIT];
    end
  end
endmodule

// File: rtl/msr_ts_guard.sv
module msr_ts_guard
  import msr_pkg::*;
(
  input  logic            dword,
  input  logic            part_l,
  input  logic [TS_W-1:0] cur_ts,
  input  logic [TS_W-1:0] src_ts,
  output logic            ts_we
);
  logic blocked;
  assign blocked = (cur_ts == TS_HELD_CUR) && (src_ts == TS_HELD_SRC);
  assign ts_we   = dword && !part_l && !blocked;
endmodule

// File: rtl/msr_next.sv
module msr_next
  import msr_pkg::*;
(
  input  word_t cur,
  input  word_t src,
  input  logic  dword,
  input  logic  part_l,
  output word_t nxt
);
  word_t forced;
  logic  ts_we;
  word_t wmask;
  word_t wdata;

  msr_force_or u_force (
    .src    (src),
    .forced (forced)
  );

  msr_ts_guard u_guard (
    .dword  (dword),
    .part_l (part_l),
    .cur_ts (cur[TS_MSB:TS_LSB]),
    .src_ts (src[TS_MSB:TS_LSB]),
    .ts_we  (ts_we)
  );

  always_comb begin
    if (part_l) begin
      wmask = M_PART;
      wdata = src;
    end else begin
      wmask = M_COMMON | M_FORCE | (dword ? M_WIDE : '0) | (ts_we ? M_TS : '0);
      wdata = (src & ~M_FORCE) | forced;
    end
    nxt = (cur & ~wmask) | (wdata & wmask);
  end
endmodule

// File: rtl/msr_write_unit.sv
module msr_write_unit
  import msr_pkg::*;
#(
  parameter logic [63:0] RST_VAL = 64'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        dword,
  input  logic        part_l,
  input  logic [63:0] src,
  output logic [63:0] msr_q
);
  word_t state_q;
  word_t state_d;

  msr_next u_next (
    .cur    (state_q),
    .src    (src),
    .dword  (dword),
    .part_l (part_l),
    .nxt    (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst)        state_q <= RST_VAL;
    else if (wr_en) state_q <= state_d;
  end

  assign msr_q = state_q;
endmodule

// File: rtl/msr_write_unit_chk.sv
module msr_write_unit_chk
  import msr_pkg::*;
#(
  parameter logic [63:0] RST_VAL = 64'h0
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        dword,
  input logic        part_l,
  input logic [63:0] src,
  input logic [63:0] msr_q
);
  localparam word_t M_NEVER = be_span(3, 3) | be_span(41, 41) | be_span(51, 51) | be_span(63, 63);

  AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> msr_q == RST_VAL); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> msr_q == $past(msr_q)); // R2

  AST_PART_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(part_l))
      |-> (msr_q & ~M_PART) == ($past(msr_q) & ~M_PART)); // R3

  AST_FORCE_ON: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(part_l) && $past(src[XLEN-1-OR_SRC_BIT]))
      |-> (msr_q & M_FORCE) == M_FORCE); // R4

  AST_NEVER_BITS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (msr_q & M_NEVER) == ($past(msr_q) & M_NEVER)); // R5

  AST_TS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(dword) && !$past(part_l)
     && $past(msr_q[TS_MSB:TS_LSB]) == TS_HELD_CUR && $past(src[TS_MSB:TS_LSB]) == TS_HELD_SRC)
      |-> msr_q[TS_MSB:TS_LSB] == TS_HELD_CUR); // R7

  AST_NARROW_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dword)) |-> msr_q[63:32] == $past(msr_q[63:32])); // R8
endmodule

bind msr_write_unit msr_write_unit_chk #(.RST_VAL(RST_VAL)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .dword  (dword),
  .part_l (part_l),
  .src    (src),
  .msr_q  (msr_q)
);

// File: tb/tb_msr_write_unit.sv
module tb_msr_write_unit;
  localparam time PERIOD = 10;
  localparam logic [63:0] RV = 64'h1000_0000_0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        dword = 1'b0;
  logic        part_l = 1'b0;
  logic [63:0] src = '0;
  logic [63:0] msr_q;

  msr_write_unit #(.RST_VAL(RV)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .dword(dword),
    .part_l(part_l), .src(src), .msr_q(msr_q)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [63:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  logic [63:0] mdl;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] bm(int n);
    return 64'd1 << (63 - n);
  endfunction

  function automatic logic [63:0] ref_next(logic [63:0] cur, logic [63:0] s, logic dw, logic l);
    logic [63:0] r;
    logic [2:0]  cts, sts;
    r = cur;
    if (l) begin
      r[63-48] = s[63-48];
      r[63-62] = s[63-62];
    end else begin
      for (int n = 32; n <= 62; n++)
        if (n != 41 && n != 48 && n != 51 && n != 58 && n != 59) r[63-n] = s[63-n];
      r[63-48] = s[63-48] | s[63-49];
      r[63-58] = s[63-58] | s[63-49];
      r[63-59] = s[63-59] | s[63-49];
      if (dw) begin
        for (int n = 0; n <= 28; n++)
          if (n != 3) r[63-n] = s[63-n];
        cts = {cur[63-29], cur[63-30], cur[63-31]};
        sts = {s[63-29], s[63-30], s[63-31]};
        if (!(cts == 3'b010 && sts == 3'b000))
          for (int n = 29; n <= 31; n++) r[63-n] = s[63-n];
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [63:0] s, input logic dw, input logic l,
                       input logic en, input string tag);
    item_t it;
    @(negedge clk);
    src = s; dword = dw; part_l = l; wr_en = en;
    if (en) mdl = ref_next(mdl, s, dw, l);
    it.exp = mdl; it.due = cyc + 1; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    wr_en = 1'b0;
    while (sbq.size() > 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (msr_q !== it.exp) begin
        fails++;
        $display("FAIL %s: msr_q=%h expected=%h", it.tag, msr_q, it.exp);
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if (msr_q !== RV) begin
      fails++;
      $display("FAIL %s: msr_q=%h expected=%h", tag, msr_q, RV);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset("R1 reset value");
    mdl = RV;

    // R2: strobe low, hostile inputs
    drive('1, 1'b1, 1'b0, 1'b0, "R2 idle hold all-ones");
    drive(64'h0123_4567_89ab_cdef, 1'b0, 1'b1, 1'b0, "R2 idle hold pattern");
    // R5 R6: doubleword full write, bits 3 41 51 63 kept
    drive('1, 1'b1, 1'b0, 1'b1, "R5 R6 doubleword all-ones");
    drive('0, 1'b1, 1'b0, 1'b1, "R5 R6 doubleword all-zeros");
    // R8: narrow variant never touches bits 0..31
    drive('1, 1'b0, 1'b0, 1'b1, "R8 narrow all-ones");
    drive(64'h0000_0000_ffff_ffff, 1'b1, 1'b0, 1'b1, "R8 setup high zero");
    drive('1, 1'b0, 1'b0, 1'b1, "R8 narrow high kept");
    // R3: partial flag
    drive('0, 1'b1, 1'b1, 1'b1, "R3 partial doubleword zeros");
    drive('1, 1'b0, 1'b1, 1'b1, "R3 partial narrow ones");
    drive(bm(48), 1'b1, 1'b1, 1'b1, "R3 partial bit48 only");
    // R4: OR forcing from source bit 49
    drive('0, 1'b1, 1'b0, 1'b1, "R4 clear");
    drive(bm(49), 1'b0, 1'b0, 1'b1, "R4 bit49 forces 48 58 59");
    drive(bm(58), 1'b1, 1'b0, 1'b1, "R4 bit58 alone");
    // R7: transaction field guard
    drive(bm(30), 1'b1, 1'b0, 1'b1, "R7 set field 010");
    drive('0, 1'b1, 1'b0, 1'b1, "R7 010 to 000 held");
    drive(~(bm(29) | bm(30) | bm(31)), 1'b1, 1'b0, 1'b1, "R7 held others written");
    drive(bm(31), 1'b1, 1'b0, 1'b1, "R7 010 to 001 written");
    drive('0, 1'b1, 1'b0, 1'b1, "R7 001 to 000 written");
    drive(bm(29) | bm(30), 1'b1, 1'b0, 1'b1, "R7 field 110");
    drive('0, 1'b1, 1'b1, 1'b1, "R7 partial ignores field");
    // R9: back-to-back mixed writes
    for (int i = 0; i < 60; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive({$urandom, $urandom}, r[0], r[1] & r[2], r[3] | r[0], "R9 mixed sequence");
    end
    drain();

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    src = '1; wr_en = 1'b1; dword = 1'b1; part_l = 1'b0;
    @(negedge clk);
    check_reset("R1 mid-run reset");
    rst = 1'b0; wr_en = 1'b0;
    mdl = RV;
    drive('0, 1'b0, 1'b1, 1'b0, "R2 hold after reset");
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule